// File: doc/BRIEF.md
# Block-Coalescing Translation Lookaside Buffer

This block caches address translations in which each entry covers a whole naturally aligned block of 2^n pages. A page walk returns one virtual page, its physical page, the block order n and a level flag. The buffer clears the low bits of both page numbers to get the block's start pages and keeps the whole range as one entry. After that, any page of the block hits, whether the pages are visited in ascending, descending or mixed order. Only two base page sizes exist: 4 kB pages for second-level entries and 1 MB sections for first-level entries. Larger mappings are expressed only through the order field.

Storage is 16 sets of 8 ways. The set index comes from virtual page bits just above the largest order, so a block always maps to exactly one set. A lookup probes the small-page set and the section set at the same time. A small-page match wins over a section match, and a lower way wins over a higher one. A miss raises a walk request that stays high until the walker delivers a fill.

A three-state controller runs the lookup path. ST_IDLE goes to ST_RESP on an accepted lookup. ST_RESP goes to ST_RESP on a hit with a new lookup, to ST_IDLE on a hit with no new lookup, to ST_WAIT on a miss with no fill, and to ST_IDLE on a miss with a fill in the same cycle. ST_WAIT goes to ST_IDLE when a fill arrives.

Top module: `bct_tlb`

## Requirements
- R1: After reset, lk_ready is 1, rsp_valid and walk_req are 0, and every lookup misses.
- R2: The result of an accepted lookup (lk_valid and lk_ready both high at a clock edge) appears on rsp_valid, rsp_hit and rsp_ppn for exactly one cycle, registered at that edge.
- R3: When a lookup misses, walk_req rises together with the response and walk_vpn carries the missed page. Both hold, with lk_ready at 0, until the cycle in which fill_valid is high. The next cycle shows walk_req 0 and lk_ready 1.
- R4: A fill of a small entry (fill_large=0) with order n covers start = fill_vpn with its low n bits cleared, through start + 2^n − 1. Any page v in that range hits with PPN = (fill_ppn with its low n bits cleared) OR (low n bits of v).
- R5: The pages just below the start and just above the end of a filled block miss.
- R6: A section entry (fill_large=1) counts its order in units of 256 pages. Its masking and comparison clear the low 8+n bits of the page number, and it is stored in the set chosen by page bits [16:13].
- R7: A fill order above 5 is stored as 5.
- R8: Each set holds 8 entries and replaces them in round-robin order per set. After 9 distinct blocks are filled into one set, the first one misses and the other 8 hit.
- R9: A fill whose level, start page and order equal those of a valid entry overwrites that entry, so the new PPN is returned at once.
- R10: A flush pulse invalidates every entry at the next edge. A flush takes priority over a fill in the same cycle.
- R11: Small entries are stored in the set chosen by page bits [8:5]. Fills into one set never evict entries of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 20 | Translated physical page number (0 on miss) |
| walk_req | output | 1 | Miss pending, walk needed |
| walk_vpn | output | 20 | Page number to walk |
| fill_valid | input | 1 | Walk result present |
| fill_vpn | input | 20 | Walked virtual page |
| fill_ppn | input | 20 | Its physical page |
| fill_order | input | 3 | Block order n |
| fill_large | input | 1 | 1 = section entry, 0 = small page entry |

## Verification
Every lookup result is due one cycle after the edge that accepts the request. The bench raises lk_valid on a falling edge and reads rsp_* and walk_* on the next falling edge, halfway through the response cycle. A fill is applied on a falling edge and takes effect at the following rising edge, so any lookup made after it sees the new entry. Flush and the return of walk_req to 0 are checked one falling edge after the edge that acts on them. The absence of the response one cycle later is checked separately.

// File: rtl/bct_pkg.sv
package bct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_WAIT = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/bct_way_match.sv
module bct_way_match #(
    parameter int VPN_W    = 20,
    parameter int PPN_W    = 20,
    parameter int ORD_W    = 3,
    parameter int WAYS     = 8,
    parameter int LG_SHIFT = 8,
    parameter bit IS_LARGE = 1'b0
) (
    input  logic [VPN_W-1:0]            vpn,
    input  logic [WAYS-1:0]             row_v,
    input  logic [WAYS-1:0]             row_lg,
    input  logic [WAYS-1:0][ORD_W-1:0]  row_ord,
    input  logic [WAYS-1:0][VPN_W-1:0]  row_svpn,
    input  logic [WAYS-1:0][PPN_W-1:0]  row_sppn,
    output logic                        hit,
    output logic [PPN_W-1:0]            ppn
);
    logic [WAYS-1:0]             way_hit;
    logic [WAYS-1:0][PPN_W-1:0]  way_ppn;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [VPN_W-1:0] low_mask;
        always_comb begin
            low_mask   = ~({VPN_W{1'b1}} << (int'(row_ord[w]) + (IS_LARGE ? LG_SHIFT : 0)));
            way_hit[w] = row_v[w] && (row_lg[w] == IS_LARGE) &&
                         ((vpn & ~low_mask) == row_svpn[w]);
            way_ppn[w] = row_sppn[w] | PPN_W'(vpn & low_mask);
        end
    end

    always_comb begin
        hit = 1'b0;
        ppn = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) begin
                hit = 1'b1;
                ppn = way_ppn[w];
            end
        end
    end
endmodule

// File: rtl/bct_victim.sv
module bct_victim #(
    parameter int VPN_W = 20,
    parameter int ORD_W = 3,
    parameter int SETS  = 16,
    parameter int WAYS  = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_en,
    input  logic [IDX_W-1:0]            set_idx,
    input  logic                        f_lg,
    input  logic [ORD_W-1:0]            f_ord,
    input  logic [VPN_W-1:0]            f_svpn,
    input  logic [WAYS-1:0]             row_v,
    input  logic [WAYS-1:0]             row_lg,
    input  logic [WAYS-1:0][ORD_W-1:0]  row_ord,
    input  logic [WAYS-1:0][VPN_W-1:0]  row_svpn,
    output logic [WAY_W-1:0]            way_sel,
    output logic                        alloc
);
    logic [SETS-1:0][WAY_W-1:0] rr_q;
    logic [WAYS-1:0]            same;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            same[w] = row_v[w] && (row_lg[w] == f_lg) &&
                      (row_ord[w] == f_ord) && (row_svpn[w] == f_svpn);
        end
        alloc   = 1'b1;
        way_sel = rr_q[set_idx];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (same[w]) begin
                alloc   = 1'b0;
                way_sel = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_en && alloc) begin
            rr_q[set_idx] <= rr_q[set_idx] + 1'b1;
        end
    end

    // R8: a new allocation advances that set's pointer by one
    p_rr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && alloc) |=> (rr_q[$past(set_idx)] == WAY_W'($past(rr_q[set_idx]) + 1'b1)));

    // R9: an overwrite leaves the pointer alone
    p_rr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !alloc) |=> $stable(rr_q));
endmodule

// File: rtl/bct_ctrl.sv
module bct_ctrl
    import bct_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             hit_now,
    input  logic [PPN_W-1:0] ppn_now,
    input  logic             fill_valid,
    output logic             lk_ready,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn
);
    ctl_state_e       state_q, state_d;
    logic             hit_q;
    logic [PPN_W-1:0] ppn_q;
    logic [VPN_W-1:0] vpn_q;
    logic             accept;

    assign accept = lk_valid && lk_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_valid) state_d = ST_RESP;
            ST_RESP: begin
                if (hit_q) state_d = lk_valid ? ST_RESP : ST_IDLE;
                else       state_d = fill_valid ? ST_IDLE : ST_WAIT;
            end
            ST_WAIT: if (fill_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= 1'b0;
            ppn_q   <= '0;
            vpn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                hit_q <= hit_now;
                ppn_q <= hit_now ? ppn_now : '0;
                vpn_q <= lk_vpn;
            end
        end
    end

    always_comb begin
        lk_ready  = 1'b0;
        rsp_valid = 1'b0;
        walk_req  = 1'b0;
        unique case (state_q)
            ST_IDLE: lk_ready = 1'b1;
            ST_RESP: begin
                rsp_valid = 1'b1;
                lk_ready  = hit_q;
                walk_req  = !hit_q;
            end
            ST_WAIT: walk_req = 1'b1;
            default: lk_ready = 1'b0;
        endcase
        rsp_hit  = rsp_valid && hit_q;
        rsp_ppn  = ppn_q;
        walk_vpn = vpn_q;
    end

    p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid);

    p_miss_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> walk_req);

    p_walk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req && !fill_valid) |=> (walk_req && $stable(walk_vpn)));

    p_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !lk_ready);
endmodule

// File: rtl/bct_tlb.sv
module bct_tlb #(
    parameter int VPN_W    = 20,
    parameter int PPN_W    = 20,
    parameter int ORD_W    = 3,
    parameter int MAX_ORD  = 5,
    parameter int LG_SHIFT = 8,
    parameter int SETS     = 16,
    parameter int WAYS     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_ready,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [ORD_W-1:0] fill_order,
    input  logic             fill_large
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int SM_LSB = MAX_ORD;
    localparam int LG_LSB = LG_SHIFT + MAX_ORD;

    logic [SETS-1:0][WAYS-1:0]             v_q;
    logic [SETS-1:0][WAYS-1:0]             lg_q;
    logic [SETS-1:0][WAYS-1:0][ORD_W-1:0]  ord_q;
    logic [SETS-1:0][WAYS-1:0][VPN_W-1:0]  svpn_q;
    logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  sppn_q;

    // fill path
    logic [ORD_W-1:0] f_ord;
    logic [VPN_W-1:0] f_vmask;
    logic [PPN_W-1:0] f_pmask;
    logic [VPN_W-1:0] f_svpn;
    logic [PPN_W-1:0] f_sppn;
    logic [IDX_W-1:0] f_set;
    logic [WAY_W-1:0] f_way;
    logic             f_alloc;
    logic             fill_en;

    always_comb begin
        f_ord   = (fill_order > ORD_W'(MAX_ORD)) ? ORD_W'(MAX_ORD) : fill_order;
        f_vmask = ~({VPN_W{1'b1}} << (int'(f_ord) + (fill_large ? LG_SHIFT : 0)));
        f_pmask = ~({PPN_W{1'b1}} << (int'(f_ord) + (fill_large ? LG_SHIFT : 0)));
        f_svpn  = fill_vpn & ~f_vmask;
        f_sppn  = fill_ppn & ~f_pmask;
        f_set   = fill_large ? fill_vpn[LG_LSB +: IDX_W] : fill_vpn[SM_LSB +: IDX_W];
        fill_en = fill_valid && !flush;
    end

    bct_victim #(.VPN_W(VPN_W), .ORD_W(ORD_W), .SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .set_idx  (f_set),
        .f_lg     (fill_large),
        .f_ord    (f_ord),
        .f_svpn   (f_svpn),
        .row_v    (v_q[f_set]),
        .row_lg   (lg_q[f_set]),
        .row_ord  (ord_q[f_set]),
        .row_svpn (svpn_q[f_set]),
        .way_sel  (f_way),
        .alloc    (f_alloc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= '0;
            lg_q   <= '0;
            ord_q  <= '0;
            svpn_q <= '0;
            sppn_q <= '0;
        end else if (flush) begin
            v_q <= '0;
        end else if (fill_valid) begin
            v_q[f_set][f_way]    <= 1'b1;
            lg_q[f_set][f_way]   <= fill_large;
            ord_q[f_set][f_way]  <= f_ord;
            svpn_q[f_set][f_way] <= f_svpn;
            sppn_q[f_set][f_way] <= f_sppn;
        end
    end

    // lookup path: probe small-page set and section set together
    logic [IDX_W-1:0] sm_set, lg_set;
    logic             sm_hit, lg_hit, hit_now;
    logic [PPN_W-1:0] sm_ppn, lg_ppn, ppn_now;

    assign sm_set = lk_vpn[SM_LSB +: IDX_W];
    assign lg_set = lk_vpn[LG_LSB +: IDX_W];

    bct_way_match #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ORD_W(ORD_W), .WAYS(WAYS),
                    .LG_SHIFT(LG_SHIFT), .IS_LARGE(1'b0)) u_match_sm (
        .vpn      (lk_vpn),
        .row_v    (v_q[sm_set]),
        .row_lg   (lg_q[sm_set]),
        .row_ord  (ord_q[sm_set]),
        .row_svpn (svpn_q[sm_set]),
        .row_sppn (sppn_q[sm_set]),
        .hit      (sm_hit),
        .ppn      (sm_ppn)
    );

    bct_way_match #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ORD_W(ORD_W), .WAYS(WAYS),
                    .LG_SHIFT(LG_SHIFT), .IS_LARGE(1'b1)) u_match_lg (
        .vpn      (lk_vpn),
        .row_v    (v_q[lg_set]),
        .row_lg   (lg_q[lg_set]),
        .row_ord  (ord_q[lg_set]),
        .row_svpn (svpn_q[lg_set]),
        .row_sppn (sppn_q[lg_set]),
        .hit      (lg_hit),
        .ppn      (lg_ppn)
    );

    assign hit_now = sm_hit || lg_hit;
    assign ppn_now = sm_hit ? sm_ppn : lg_ppn;

    bct_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_vpn     (lk_vpn),
        .hit_now    (hit_now),
        .ppn_now    (ppn_now),
        .fill_valid (fill_valid),
        .lk_ready   (lk_ready),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_ppn    (rsp_ppn),
        .walk_req   (walk_req),
        .walk_vpn   (walk_vpn)
    );

    p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (v_q == '0));

    p_miss_zero_ppn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0));
endmodule

// File: tb/bct_tlb_test.sv
module bct_tlb_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_ready, rsp_valid, rsp_hit, walk_req;
    logic [19:0] rsp_ppn, walk_vpn;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [2:0]  fill_order = '0;
    logic        fill_large = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bct_tlb uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_order(fill_order), .fill_large(fill_large)
    );

    typedef struct packed {
        logic [19:0] vpn;
        logic        hit;
        logic [19:0] ppn;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{20'h01237, 1'b1, 20'h0ABC7, 4'd4},  // R4 top of block
        '{20'h01234, 1'b1, 20'h0ABC4, 4'd4},  // R4 start, descending
        '{20'h01235, 1'b1, 20'h0ABC5, 4'd4},  // R4 middle
        '{20'h01233, 1'b0, 20'h00000, 4'd5},  // R5 below start
        '{20'h01238, 1'b0, 20'h00000, 4'd5},  // R5 above end
        '{20'h457FF, 1'b1, 20'h9A1FF, 4'd6},  // R6 section top
        '{20'h45600, 1'b1, 20'h9A000, 4'd6},  // R6 section start
        '{20'h455FF, 1'b0, 20'h00000, 4'd6},  // R6 below section
        '{20'h45800, 1'b0, 20'h00000, 4'd6},  // R6 above section
        '{20'h20003, 1'b1, 20'h30043, 4'd7},  // R7 order 7 held as 5
        '{20'h2001F, 1'b1, 20'h3005F, 4'd7}   // R7 clamped range end
    };

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic do_fill(input logic [19:0] v, input logic [19:0] p,
                           input logic [2:0] o, input logic lg);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = p; fill_order = o; fill_large = lg;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // lookup; on a miss answers the walk with a harmless fill in set 15
    task automatic do_lookup(input logic [19:0] v, input logic eh,
                             input logic [19:0] ep, input int rq);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid == 1'b1, rq, "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_hit == eh, rq, "rsp_hit", 32'(rsp_hit), 32'(eh));
        if (eh) chk(rsp_ppn == ep, rq, "rsp_ppn", 32'(rsp_ppn), 32'(ep));
        if (!rsp_hit) begin
            chk(walk_req && walk_vpn == v, rq, "walk_vpn", 32'(walk_vpn), 32'(v));
            fill_valid = 1'b1; fill_vpn = 20'h001E0; fill_ppn = 20'hFFFFF;
            fill_order = 3'd0; fill_large = 1'b0;
            @(negedge clk);
            fill_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(lk_ready == 1'b1, 1, "lk_ready", 32'(lk_ready), 32'd1);
        chk(rsp_valid == 1'b0, 1, "rsp_valid", 32'(rsp_valid), 32'd0);
        chk(walk_req == 1'b0, 1, "walk_req", 32'(walk_req), 32'd0);
        do_lookup(20'h01236, 1'b0, 20'h0, 1);   // R1 empty buffer misses

        do_fill(20'h01236, 20'h0ABC6, 3'd2, 1'b0);
        do_fill(20'h45678, 20'h9A0FF, 3'd1, 1'b1);
        do_fill(20'h20011, 20'h30051, 3'd7, 1'b0);
        for (int i = 0; i < NV; i++)
            do_lookup(VECS[i].vpn, VECS[i].hit, VECS[i].ppn, int'(VECS[i].req));

        // R2 response lasts exactly one cycle
        do_lookup(20'h01236, 1'b1, 20'h0ABC6, 2);
        @(negedge clk);
        chk(rsp_valid == 1'b0, 2, "rsp_valid after", 32'(rsp_valid), 32'd0);

        // R3 miss holds walk until the fill arrives
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'h7F00F;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid && !rsp_hit, 3, "miss rsp", 32'(rsp_hit), 32'd0);
        repeat (3) @(negedge clk);
        chk(walk_req == 1'b1, 3, "walk_req held", 32'(walk_req), 32'd1);
        chk(walk_vpn == 20'h7F00F, 3, "walk_vpn held", 32'(walk_vpn), 32'h7F00F);
        chk(lk_ready == 1'b0, 3, "lk_ready busy", 32'(lk_ready), 32'd0);
        fill_valid = 1'b1; fill_vpn = 20'h7F00F; fill_ppn = 20'h1200F;
        fill_order = 3'd0; fill_large = 1'b0;
        @(negedge clk);
        fill_valid = 1'b0;
        chk(walk_req == 1'b0, 3, "walk_req done", 32'(walk_req), 32'd0);
        chk(lk_ready == 1'b1, 3, "lk_ready back", 32'(lk_ready), 32'd1);
        do_lookup(20'h7F00F, 1'b1, 20'h1200F, 3);

        // R9 refill of the same block overwrites
        do_fill(20'h00700, 20'h11111, 3'd0, 1'b0);
        do_fill(20'h00700, 20'h22222, 3'd0, 1'b0);
        do_lookup(20'h00700, 1'b1, 20'h22222, 9);

        // R8 round robin in set 3, R11 set 4 untouched
        do_fill(20'h00080, 20'h55555, 3'd0, 1'b0);
        for (int k = 0; k < 9; k++)
            do_fill(20'h00060 + 20'(k) * 20'h200, 20'h60000 + 20'(k), 3'd0, 1'b0);
        do_lookup(20'h00060, 1'b0, 20'h0, 8);
        for (int k = 1; k < 9; k++)
            do_lookup(20'h00060 + 20'(k) * 20'h200, 1'b1, 20'h60000 + 20'(k), 8);
        do_lookup(20'h00080, 1'b1, 20'h55555, 11);

        // R10 flush beats a simultaneous fill
        @(negedge clk);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h00900;
        fill_ppn = 20'h77777; fill_order = 3'd0; fill_large = 1'b0;
        @(negedge clk);
        flush = 1'b0; fill_valid = 1'b0;
        do_lookup(20'h01235, 1'b0, 20'h0, 10);
        do_lookup(20'h45600, 1'b0, 20'h0, 10);
        do_lookup(20'h00900, 1'b0, 20'h0, 10);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule